// File: doc/BRIEF.md
# Multi-Width Adder with Condition Flags

This block adds two operands at one of three widths (byte, halfword, word), each read as signed or unsigned, and registers the width-limited sum together with carry, overflow, negative and zero condition flags. Bits of the operands above the selected width are discarded before the addition. It suits an execution stage whose later instructions test the flags.

The flags follow one rule for both signednesses except overflow. For signed types, overflow is the two's-complement rule: both addends have the same sign and the sum's sign differs. For unsigned types, overflow repeats the carry, so software that tests overflow can detect a carry out of the top bit of an unsigned add. Results and flags load on a cycle where `in_valid` is high and hold at all other times.

Top module: `mwadd_flags`

## Requirements
- R1: A synchronous active-low reset clears `sum_q` and all four flags to 0 on the next rising edge.
- R2: `op_type` encodings are 0 signed word, 1 unsigned word, 2 signed halfword, 3 unsigned halfword, 4 signed byte and 5 unsigned byte. Word is 32 bits, halfword 16 and byte 8. Operand bits above the selected width are ignored, and `sum_q` bits above it read 0.
- R3: `c_q` is 1 when the full-precision sum of the width-limited operands exceeds the all-ones value of the selected width. This applies to both signed and unsigned types.
- R4: For signed types (codes 0, 2, 4), `v_q` is 1 when the two operands share a sign bit and the sum's sign bit differs from it. The sign bit is bit 31, 15 or 7 for word, halfword or byte.
- R5: For unsigned types (codes 1, 3, 5), `v_q` equals `c_q`.
- R6: `n_q` is the sum's bit at the top of the selected width (bit 31, 15 or 7). `z_q` is 1 exactly when the width-limited sum is zero.
- R7: When `in_valid` is low, `sum_q` and all flags keep their values, whatever the operand and type inputs do.
- R8: Reserved codes 6 and 7 behave exactly as unsigned word (code 1).
- R9: Results and flags for an operation with `in_valid` high appear on the outputs after the rising edge that samples it. Back-to-back operations produce one result per cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Load strobe for a new addition |
| op_a | input | 32 | First addend |
| op_b | input | 32 | Second addend |
| op_type | input | 3 | Operand type code |
| sum_q | output | 32 | Registered width-limited sum |
| c_q | output | 1 | Registered carry flag |
| v_q | output | 1 | Registered overflow flag |
| n_q | output | 1 | Registered negative flag |
| z_q | output | 1 | Registered zero flag |

## Verification
The assertions assume that `in_valid`, `op_type` and the operands are known, non-X values at every rising edge after reset. They also assume the inputs change only between edges, so `$past` of an input is the value the design loaded. The stimulus meets these conditions by driving every input from a defined value at time zero and updating the inputs only on falling edges. Operand bits above the selected width are filled with nonzero values, so the discarding of those bits is exercised rather than assumed.

// File: rtl/mwadd_pkg.sv
// Shared types for the multi-width adder: lane identifiers and the flag bundle.
package mwadd_pkg;
    localparam int NUM_LANES = 3;

    typedef enum logic [1:0] {
        LANE_WORD = 2'd0,
        LANE_HALF = 2'd1,
        LANE_BYTE = 2'd2
    } lane_e;

    typedef struct packed {
        logic c;
        logic v;
        logic n;
        logic z;
    } flags_t;
endpackage

// File: rtl/mwadd_type_decode.sv
// Maps the 3-bit operand type code to a lane and a signedness.
// Assumes codes 6 and 7 are reserved and treated as unsigned word.
module mwadd_type_decode
    import mwadd_pkg::*;
(
    input  logic [2:0] type_code,
    output lane_e      lane_sel,
    output logic       is_signed
);
    // Decode type code into width lane and sign interpretation.
    always_comb begin
        case (type_code)
            3'd0:    begin lane_sel = LANE_WORD; is_signed = 1'b1; end
            3'd1:    begin lane_sel = LANE_WORD; is_signed = 1'b0; end
            3'd2:    begin lane_sel = LANE_HALF; is_signed = 1'b1; end
            3'd3:    begin lane_sel = LANE_HALF; is_signed = 1'b0; end
            3'd4:    begin lane_sel = LANE_BYTE; is_signed = 1'b1; end
            3'd5:    begin lane_sel = LANE_BYTE; is_signed = 1'b0; end
            default: begin lane_sel = LANE_WORD; is_signed = 1'b0; end
        endcase
    end
endmodule

// File: rtl/mwadd_lane.sv
// One fixed-width adder lane. Adds the low LANE_W bits of each operand with
// one extra bit of precision and reports the zero-extended sum, the carry out,
// the signed overflow, the sign bit and a zero indication.
// Assumes OUT_W >= LANE_W.
module mwadd_lane #(
    parameter int LANE_W = 8,
    parameter int OUT_W  = 32
) (
    input  logic [LANE_W-1:0] a,
    input  logic [LANE_W-1:0] b,
    output logic [OUT_W-1:0]  sum_ext,
    output logic              carry,
    output logic              sovf,
    output logic              neg,
    output logic              zero
);
    localparam int FULL_W = LANE_W + 1;

    logic [FULL_W-1:0] full_sum;
    logic [LANE_W-1:0] lane_sum;

    // Extended-precision addition and per-lane flag derivation.
    always_comb begin
        full_sum = {1'b0, a} + {1'b0, b};
        lane_sum = full_sum[LANE_W-1:0];
        carry    = full_sum[LANE_W];
        sovf     = (a[LANE_W-1] == b[LANE_W-1]) && (lane_sum[LANE_W-1] != a[LANE_W-1]);
        neg      = lane_sum[LANE_W-1];
        zero     = (lane_sum == '0);
        sum_ext  = OUT_W'(lane_sum);
    end
endmodule

// File: rtl/mwadd_flag_select.sv
// Picks the result and flags of the selected lane. Overflow comes from the
// signed rule for signed types and from the carry for unsigned types.
module mwadd_flag_select
    import mwadd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = 3
) (
    input  logic [LANES-1:0][DATA_W-1:0] lane_sum,
    input  logic [LANES-1:0]             lane_carry,
    input  logic [LANES-1:0]             lane_sovf,
    input  logic [LANES-1:0]             lane_neg,
    input  logic [LANES-1:0]             lane_zero,
    input  lane_e                        lane_sel,
    input  logic                         is_signed,
    output logic [DATA_W-1:0]            sum_sel,
    output flags_t                       flags_sel
);
    localparam int IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic [IDX_W-1:0] idx;

    // Multiplex lane outputs and apply the signedness-dependent overflow rule.
    always_comb begin
        idx         = IDX_W'(lane_sel);
        sum_sel     = lane_sum[idx];
        flags_sel.c = lane_carry[idx];
        flags_sel.v = is_signed ? lane_sovf[idx] : lane_carry[idx];
        flags_sel.n = lane_neg[idx];
        flags_sel.z = lane_zero[idx];
    end
endmodule

// File: rtl/mwadd_flags.sv
// Multi-width adder with registered condition flags. Three adder lanes
// (word, halfword, byte) run in parallel on the low bits of the operands.
// The type code picks one lane, and its sum and flags load on in_valid.
// Assumes inputs are stable around the rising clock edge.
module mwadd_flags
    import mwadd_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int HALF_W = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [2:0]        op_type,
    output logic [WORD_W-1:0] sum_q,
    output logic              c_q,
    output logic              v_q,
    output logic              n_q,
    output logic              z_q
);
    logic [NUM_LANES-1:0][WORD_W-1:0] lane_sum;
    logic [NUM_LANES-1:0]             lane_carry;
    logic [NUM_LANES-1:0]             lane_sovf;
    logic [NUM_LANES-1:0]             lane_neg;
    logic [NUM_LANES-1:0]             lane_zero;
    lane_e                            lane_sel;
    logic                             is_signed;
    logic [WORD_W-1:0]                sum_sel;
    flags_t                           flags_sel;

    mwadd_type_decode u_decode (
        .type_code (op_type),
        .lane_sel  (lane_sel),
        .is_signed (is_signed)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        localparam int LW = (g == 0) ? WORD_W : (g == 1) ? HALF_W : BYTE_W;
        mwadd_lane #(
            .LANE_W (LW),
            .OUT_W  (WORD_W)
        ) u_lane (
            .a       (op_a[LW-1:0]),
            .b       (op_b[LW-1:0]),
            .sum_ext (lane_sum[g]),
            .carry   (lane_carry[g]),
            .sovf    (lane_sovf[g]),
            .neg     (lane_neg[g]),
            .zero    (lane_zero[g])
        );
    end

    mwadd_flag_select #(
        .DATA_W (WORD_W),
        .LANES  (NUM_LANES)
    ) u_select (
        .lane_sum   (lane_sum),
        .lane_carry (lane_carry),
        .lane_sovf  (lane_sovf),
        .lane_neg   (lane_neg),
        .lane_zero  (lane_zero),
        .lane_sel   (lane_sel),
        .is_signed  (is_signed),
        .sum_sel    (sum_sel),
        .flags_sel  (flags_sel)
    );

    // Result and flag register: cleared by reset, loaded on in_valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            c_q   <= 1'b0;
            v_q   <= 1'b0;
            n_q   <= 1'b0;
            z_q   <= 1'b0;
        end else if (in_valid) begin
            sum_q <= sum_sel;
            c_q   <= flags_sel.c;
            v_q   <= flags_sel.v;
            n_q   <= flags_sel.n;
            z_q   <= flags_sel.z;
        end
    end
endmodule

// File: rtl/mwadd_flags_checker.sv
// Temporal checks on the multi-width adder's registered outputs.
module mwadd_flags_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [31:0] op_a,
    input logic [31:0] op_b,
    input logic [2:0]  op_type,
    input logic [31:0] sum_q,
    input logic        c_q,
    input logic        v_q,
    input logic        n_q,
    input logic        z_q
);
    // R1: reset clears everything
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (sum_q == 32'd0 && !c_q && !v_q && !n_q && !z_q));

    // R7: outputs hold while idle
    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sum_q) && $stable(c_q) && $stable(v_q) &&
                       $stable(n_q) && $stable(z_q)));

    // R5 and R8: unsigned types report overflow equal to carry
    assert_unsigned_v_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_type == 3'd1 || op_type == 3'd3 || op_type == 3'd5 ||
                      op_type == 3'd6 || op_type == 3'd7)) |=> (v_q == c_q));

    // R2: byte and halfword results carry no bits above their width
    assert_byte_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_type == 3'd4 || op_type == 3'd5)) |=> (sum_q[31:8] == 24'd0));

    assert_half_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_type == 3'd2 || op_type == 3'd3)) |=> (sum_q[31:16] == 16'd0));

    // R6: zero flag agrees with the loaded sum
    assert_zero_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (z_q == (sum_q == 32'd0)));

    // R6: negative flag of a byte type is bit 7 of the sum
    assert_byte_neg_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_type == 3'd4 || op_type == 3'd5)) |=> (n_q == sum_q[7]));

    // R4: signed byte overflow rule
    assert_sbyte_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_type == 3'd4) |=>
        (v_q == (($past(op_a[7]) == $past(op_b[7])) && (sum_q[7] != $past(op_a[7])))));

    // R4: signed word overflow rule
    assert_sword_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_type == 3'd0) |=>
        (v_q == (($past(op_a[31]) == $past(op_b[31])) && (sum_q[31] != $past(op_a[31])))));
endmodule

bind mwadd_flags mwadd_flags_checker u_mwadd_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .op_a     (op_a),
    .op_b     (op_b),
    .op_type  (op_type),
    .sum_q    (sum_q),
    .c_q      (c_q),
    .v_q      (v_q),
    .n_q      (n_q),
    .z_q      (z_q)
);

// File: tb/mwadd_flags_bench.sv
// Scoreboard bench: the driver queues expected results, the monitor compares.
module mwadd_flags_bench;
    typedef struct {
        logic [31:0] sum;
        logic        c;
        logic        v;
        logic        n;
        logic        z;
        logic [2:0]  ty;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = 32'd0;
    logic [31:0] op_b = 32'd0;
    logic [2:0]  op_type = 3'd0;
    logic [31:0] sum_q;
    logic        c_q, v_q, n_q, z_q;

    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;
    exp_t sb_q[$];
    exp_t last_exp;
    logic [31:0] rng = 32'h1234_5678;

    always #4 clk = ~clk;

    mwadd_flags u_mwadd_flags (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_type(op_type),
        .sum_q(sum_q), .c_q(c_q), .v_q(v_q), .n_q(n_q), .z_q(z_q)
    );

    // Reference model computed from the requirements.
    function automatic exp_t model(logic [31:0] a, logic [31:0] b, logic [2:0] ty);
        exp_t e;
        int msb;
        logic [31:0] mask;
        logic [32:0] full;
        logic [31:0] am, bm;
        bit sgn;
        case (ty)
            3'd2, 3'd3: begin msb = 15; mask = 32'h0000_FFFF; end
            3'd4, 3'd5: begin msb = 7;  mask = 32'h0000_00FF; end
            default:    begin msb = 31; mask = 32'hFFFF_FFFF; end
        endcase
        sgn   = (ty == 3'd0 || ty == 3'd2 || ty == 3'd4);
        am    = a & mask;
        bm    = b & mask;
        full  = {1'b0, am} + {1'b0, bm};
        e.c   = (full > {1'b0, mask});
        e.sum = full[31:0] & mask;
        e.v   = sgn ? (((am ^ ~bm) & (am ^ e.sum)) >> msb) & 1'b1 : e.c;
        e.n   = e.sum[msb];
        e.z   = (e.sum == 32'd0);
        e.ty  = ty;
        return e;
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] next_rng();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    // Driver: present one operation for one edge and queue its expectation.
    task automatic drive(logic [31:0] a, logic [31:0] b, logic [2:0] ty);
        @(negedge clk);
        op_a     = a;
        op_b     = b;
        op_type  = ty;
        in_valid = 1'b1;
        sb_q.push_back(model(a, b, ty));
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            op_a     = next_rng();
            op_b     = next_rng();
            op_type  = next_rng() % 8;
        end
    endtask

    // Monitor: compare outputs just after each loading edge (R9).
    always @(posedge clk) begin
        if (rst_n && in_valid) begin
            exp_t e;
            string vr;
            string gr;
            #1;
            if (sb_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R9 unexpected load actual=%h expected=none", sum_q);
            end else begin
                e  = sb_q.pop_front();
                gr = (e.ty > 3'd5) ? "R8" : "";
                vr = (gr != "") ? gr : ((e.ty == 3'd0 || e.ty == 3'd2 || e.ty == 3'd4) ? "R4" : "R5");
                check((gr != "") ? gr : "R2", "sum", sum_q, e.sum);
                check((gr != "") ? gr : "R3", "carry", {31'd0, c_q}, {31'd0, e.c});
                check(vr, "overflow", {31'd0, v_q}, {31'd0, e.v});
                check((gr != "") ? gr : "R6", "negative", {31'd0, n_q}, {31'd0, e.n});
                check((gr != "") ? gr : "R6", "zero", {31'd0, z_q}, {31'd0, e.z});
                last_exp = e;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        check("R1", "reset sum", sum_q, 32'd0);
        check("R1", "reset flags", {28'd0, c_q, v_q, n_q, z_q}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corners
        drive(32'h7FFF_FFFF, 32'h0000_0001, 3'd0); // R4 signed word overflow
        drive(32'hFFFF_FFFF, 32'h0000_0001, 3'd0); // R3 carry without overflow
        drive(32'hFFFF_FFFF, 32'h0000_0001, 3'd1); // R5 unsigned: v follows c
        drive(32'h8000_0000, 32'h8000_0000, 3'd1);
        drive(32'hABCD_7FFF, 32'h1234_0001, 3'd2); // R2 upper bits ignored, R4
        drive(32'hFFFF_FFFF, 32'h5555_0001, 3'd3); // R5 halfword carry
        drive(32'h1234_5680, 32'hFEDC_BA80, 3'd4); // R4 signed byte overflow
        drive(32'hFFFF_FF7F, 32'h0000_0001, 3'd5); // R6 negative, no carry
        drive(32'h0000_007F, 32'hFFFF_FF01, 3'd4); // R4 positive overflow
        drive(32'h0000_00FF, 32'h0000_00FF, 3'd5); // R3 byte carry, nonzero
        drive(32'hFFFF_FFFF, 32'h0000_0002, 3'd6); // R8 reserved
        drive(32'h7FFF_FFFF, 32'h0000_0001, 3'd7); // R8 reserved: no signed rule
        drive(32'h0000_0000, 32'h0000_0000, 3'd0); // R6 zero
        idle(2);
        // R7: idle cycles with wandering inputs leave outputs untouched
        #1;
        check("R7", "hold sum", sum_q, last_exp.sum);
        check("R7", "hold flags", {28'd0, c_q, v_q, n_q, z_q},
              {28'd0, last_exp.c, last_exp.v, last_exp.n, last_exp.z});

        // Pseudo-random operations over every type code
        for (int t = 0; t < 8; t++) begin
            for (int k = 0; k < 12; k++) begin
                drive(next_rng(), next_rng(), 3'(t));
            end
        end
        drive(32'h0000_0080, 32'h0000_0080, 3'd5);
        idle(3);
        #1;
        check("R7", "hold after burst", sum_q, last_exp.sum);

        // R1: reset in mid-run clears loaded state
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        check("R1", "mid reset sum", sum_q, 32'd0);
        check("R1", "mid reset flags", {28'd0, c_q, v_q, n_q, z_q}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(32'h0000_FFFF, 32'h0000_0001, 3'd3);
        idle(2);
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R9 pending results actual=%0d expected=0", sb_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule